// File: doc/BRIEF.md
# I2C Line Stall and Bus-Idle Monitor

This block watches the sampled clock and data lines of an I2C master and reports two conditions to the master's control logic. The first is a sticky stall flag. It rises when the watched line has been held low, with no transition, for a programmable number of prescaler ticks. The count is a configuration field multiplied by 256. The second is a bus-idle indication. It tells the master that both lines have stayed high long enough for the bus to count as free.

All counting advances only on clock cycles where the prescaler tick enable is high. A select input chooses which line the stall timer watches: the clock line or the data line. When the monitor is disabled or held in soft reset, all of its state clears synchronously. Clearing the enable or raising soft reset is also the only way to remove a stall flag that has been raised. The idle threshold changes start-up behaviour. With a threshold of zero, the bus counts as idle as soon as the monitor is enabled. With a nonzero threshold, the lines must first stay high for that many ticks.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After `rst_n` is sampled low, and on the clock after any edge where `mon_en` is low or `soft_rst` is high, both `stall_flag` and `bus_idle` read 0 and all internal counts restart from zero.
- R2: With `stall_limit` = N (nonzero), `stall_flag` rises on the clock edge of the (N×256)th tick taken while the watched line is low with no transition, and not before.
- R3: `watch_sda` = 0 makes the clock line (`scl_in`) the watched line; `watch_sda` = 1 makes it the data line (`sda_in`). The line that is not watched has no effect on the stall count.
- R4: Any change of the watched line between two sampled clock edges restarts the low-time count at zero, and the clock on which the change is seen does not count.
- R5: Once `stall_flag` is 1 it stays 1, even if the line returns high, until `mon_en` is low or `soft_rst` is high at a clock edge.
- R6: A `stall_limit` of zero disables the stall flag.
- R7: Clock cycles with `tick` low do not advance either count.
- R8: With `idle_limit` = 0, `bus_idle` is 1 from the first clock edge at which the monitor is enabled, provided both lines are high.
- R9: With `idle_limit` = M (nonzero), `bus_idle` rises on the edge of the Mth tick during which both lines are high, and not before.
- R10: `bus_idle` drops in the same cycle that either line is low, and a low sample restarts the idle count at zero.
- R11: With `idle_limit` = 0, once a low line has cleared the idle state, `bus_idle` stays 0 until the monitor is disabled and enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaler tick enable; counts advance only when high |
| mon_en | input | 1 | Monitor enable; low clears all state |
| soft_rst | input | 1 | Soft reset; high clears all state |
| watch_sda | input | 1 | 0 watches the clock line, 1 watches the data line |
| stall_limit | input | LIM_W | Stall threshold in units of 256 ticks; zero disables |
| idle_limit | input | IDLE_W | Ticks with both lines high before the bus is idle |
| scl_in | input | 1 | Sampled I2C clock line |
| sda_in | input | 1 | Sampled I2C data line |
| stall_flag | output | 1 | Sticky watched-line-low timeout flag |
| bus_idle | output | 1 | Bus counted as idle |

## Verification
The hardest case to reach is the exact threshold of the stall flag after a restart partway through the count. The count runs in 256-tick units and ignores cycles where no tick is given. The bench therefore drives ticks one clock at a time. It lets the edge clock pass with the tick held low. It then holds the line low for 200 ticks, releases it for one cycle, lowers it again, and checks that the flag is still 0 after 255 more ticks and becomes 1 on the 256th. The same tick-by-tick counting places the idle threshold exactly, both at enable time and after a low pulse on the data line.

// File: rtl/i2c_mon_pkg.sv
// Package i2c_mon_pkg
// Shared constants and types for the I2C line monitor.
// Assumes: the low-time scale is a fixed power of two (256 ticks per unit).
package i2c_mon_pkg;

    // Number of prescaler ticks per unit of the stall threshold, as a shift
    localparam int unsigned STALL_SHIFT = 8;

    // Index of each line inside a sampled pair
    localparam int unsigned LINE_SCL = 0;
    localparam int unsigned LINE_SDA = 1;
    localparam int unsigned NUM_LINES = 2;

    // Sampled pair of bus lines
    typedef logic [NUM_LINES-1:0] line_pair_t;

endpackage

// File: rtl/i2cmon_edge_track.sv
// Module i2cmon_edge_track
// Keeps the previous sample of each bus line and flags any change.
// Assumes: the line inputs are already synchronised to clk. The history runs
// whether or not the monitor is enabled, so an edge is never missed at enable.
module i2cmon_edge_track
    import i2c_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  line_pair_t lines,
    output line_pair_t changed
);

    line_pair_t prev_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Hold the previous sample of this line; idle level after reset is high
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b1;
            else        prev_q[g] <= lines[g];
        end

        // A change is any difference from the previous sample
        assign changed[g] = lines[g] ^ prev_q[g];
    end

endmodule

// File: rtl/i2cmon_low_timer.sv
// Module i2cmon_low_timer
// Counts ticks while the watched line is low and steady, and raises a sticky
// flag at limit*256 ticks.
// Assumes: `active` folds in enable and soft reset; a zero limit disables the flag.
module i2cmon_low_timer
    import i2c_mon_pkg::*;
#(
    parameter int unsigned LIM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic             line,
    input  logic             line_changed,
    input  logic [LIM_W-1:0] limit,
    output logic             flag
);

    localparam int unsigned CNT_W = LIM_W + STALL_SHIFT;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] target;
    logic             flag_q;
    logic             counting;

    // Threshold scaled to ticks; the count is wide enough to hold it
    assign target   = {limit, {STALL_SHIFT{1'b0}}};
    assign cnt_inc  = cnt_q + 1'b1;
    assign counting = tick && (limit != '0) && (cnt_q != target);

    // Low-time counter: cleared on high level, on any change, or when inactive
    always_ff @(posedge clk) begin
        if (!rst_n || !active)        cnt_q <= '0;
        else if (line || line_changed) cnt_q <= '0;
        else if (counting)            cnt_q <= cnt_inc;
    end

    // Sticky flag: set when the count reaches its target, cleared only by inactivity
    always_ff @(posedge clk) begin
        if (!rst_n || !active) flag_q <= 1'b0;
        else if (!line && !line_changed && counting && (cnt_inc == target))
            flag_q <= 1'b1;
    end

    assign flag = flag_q;

endmodule

// File: rtl/i2cmon_idle_timer.sv
// Module i2cmon_idle_timer
// Decides when the bus counts as idle from how long both lines stay high.
// Assumes: a zero limit means "idle at enable", with no later return to idle
// by this block (that needs stop detection elsewhere).
module i2cmon_idle_timer #(
    parameter int unsigned IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tick,
    input  logic              both_high,
    input  logic [IDLE_W-1:0] limit,
    output logic              idle
);

    logic [IDLE_W-1:0] cnt_q;
    logic [IDLE_W-1:0] cnt_inc;
    logic              idle_q;
    logic              fresh_q;

    assign cnt_inc = cnt_q + 1'b1;

    // First-cycle marker: set while inactive, cleared after the first active edge
    always_ff @(posedge clk) begin
        if (!rst_n || !active) fresh_q <= 1'b1;
        else                   fresh_q <= 1'b0;
    end

    // High-time counter: counts ticks with both lines high until idle is declared
    always_ff @(posedge clk) begin
        if (!rst_n || !active)                   cnt_q <= '0;
        else if (!both_high)                     cnt_q <= '0;
        else if (tick && !idle_q && limit != '0) cnt_q <= cnt_inc;
    end

    // Idle state: set on enable (zero limit) or at the threshold, cleared by a low line
    always_ff @(posedge clk) begin
        if (!rst_n || !active)  idle_q <= 1'b0;
        else if (!both_high)    idle_q <= 1'b0;
        else if (limit == '0) begin
            if (fresh_q) idle_q <= 1'b1;
        end
        else if (tick && !idle_q && cnt_inc == limit)
            idle_q <= 1'b1;
    end

    // Drop at once when a line falls, without waiting for an edge
    assign idle = idle_q && both_high;

endmodule

// File: rtl/i2c_bus_monitor.sv
// Module i2c_bus_monitor
// Top of the I2C line monitor: stall timeout on one selected line, plus
// bus-idle detection on both lines.
// Assumes: scl_in/sda_in are synchronised samples; tick is a one-cycle
// prescaler enable; configuration is held stable while the monitor runs.
module i2c_bus_monitor
    import i2c_mon_pkg::*;
#(
    parameter int unsigned LIM_W  = 4,
    parameter int unsigned IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              mon_en,
    input  logic              soft_rst,
    input  logic              watch_sda,
    input  logic [LIM_W-1:0]  stall_limit,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              stall_flag,
    output logic              bus_idle
);

    line_pair_t lines;
    line_pair_t changed;
    logic       active;
    logic       watched;
    logic       watched_chg;

    assign lines[LINE_SCL] = scl_in;
    assign lines[LINE_SDA] = sda_in;
    assign active          = mon_en && !soft_rst;

    // Route the chosen line and its change marker to the stall timer
    assign watched     = watch_sda ? lines[LINE_SDA]   : lines[LINE_SCL];
    assign watched_chg = watch_sda ? changed[LINE_SDA] : changed[LINE_SCL];

    i2cmon_edge_track u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines   (lines),
        .changed (changed)
    );

    i2cmon_low_timer #(
        .LIM_W (LIM_W)
    ) u_stall (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (active),
        .tick         (tick),
        .line         (watched),
        .line_changed (watched_chg),
        .limit        (stall_limit),
        .flag         (stall_flag)
    );

    i2cmon_idle_timer #(
        .IDLE_W (IDLE_W)
    ) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .tick      (tick),
        .both_high (&lines),
        .limit     (idle_limit),
        .idle      (bus_idle)
    );

endmodule

// File: rtl/i2c_bus_monitor_chk.sv
// Module i2c_bus_monitor_chk
// Assertion checker for i2c_bus_monitor, attached by bind.
// Assumes: the same clock and synchronous active-low reset as the monitor.
module i2c_bus_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic mon_en,
    input logic soft_rst,
    input logic watch_sda,
    input logic scl_in,
    input logic sda_in,
    input logic stall_flag,
    input logic bus_idle
);

    // R1
    inactive_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_en || soft_rst) |=> (!stall_flag && !bus_idle));

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_flag && mon_en && !soft_rst) |=> stall_flag);

    // R2
    flag_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_flag) |-> $past(watch_sda ? !sda_in : !scl_in));

    // R7
    flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_flag) |-> $past(tick));

    // R8
    idle_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_idle) |-> $past(mon_en && !soft_rst));

    // R10
    idle_low_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_in || !sda_in) |-> !bus_idle);

endmodule

bind i2c_bus_monitor i2c_bus_monitor_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .mon_en     (mon_en),
    .soft_rst   (soft_rst),
    .watch_sda  (watch_sda),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .stall_flag (stall_flag),
    .bus_idle   (bus_idle)
);

// File: tb/sim_i2c_bus_monitor.sv
// Directed bench for i2c_bus_monitor: one task per scenario.
module sim_i2c_bus_monitor;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned LIM_W      = 4;
    localparam int unsigned IDLE_W     = 8;
    localparam int unsigned WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              tick;
    logic              mon_en;
    logic              soft_rst;
    logic              watch_sda;
    logic [LIM_W-1:0]  stall_limit;
    logic [IDLE_W-1:0] idle_limit;
    logic              scl_in;
    logic              sda_in;
    logic              stall_flag;
    logic              bus_idle;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_bus_monitor #(.LIM_W(LIM_W), .IDLE_W(IDLE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mon_en(mon_en),
        .soft_rst(soft_rst), .watch_sda(watch_sda), .stall_limit(stall_limit),
        .idle_limit(idle_limit), .scl_in(scl_in), .sda_in(sda_in),
        .stall_flag(stall_flag), .bus_idle(bus_idle)
    );

    // Watchdog: a hung run is a failed check and still reports
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            checks++; failures++;
            $display("FAIL watchdog: run exceeded %0d cycles", WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One clock; inputs change and outputs are read 1 time unit after the edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        step(n);
        tick = 1'b0;
    endtask

    // Disable, load configuration and lines, enable again
    task automatic restart(input logic [LIM_W-1:0] sl, input logic [IDLE_W-1:0] il,
                           input logic wsda);
        mon_en = 1'b0; tick = 1'b0; soft_rst = 1'b0;
        scl_in = 1'b1; sda_in = 1'b1;
        step(2);
        stall_limit = sl; idle_limit = il; watch_sda = wsda;
        mon_en = 1'b1;
        step(1);
    endtask

    task automatic t_reset;
        check("R1 reset stall_flag", stall_flag, 1'b0);
        check("R1 reset bus_idle", bus_idle, 1'b0);
    endtask

    task automatic t_idle_zero;
        restart(4'd1, 8'd0, 1'b0);
        check("R8 idle at enable", bus_idle, 1'b1);
        scl_in = 1'b0; #1;
        check("R10 idle drops with scl low", bus_idle, 1'b0);
        step(1); scl_in = 1'b1;
        ticks(20);
        check("R11 idle stays low after activity", bus_idle, 1'b0);
        mon_en = 1'b0; step(1);
        check("R1 disable clears idle", bus_idle, 1'b0);
        mon_en = 1'b1; step(1);
        check("R11 idle after re-enable", bus_idle, 1'b1);
    endtask

    task automatic t_idle_count;
        restart(4'd1, 8'd5, 1'b0);
        step(3);
        check("R7 idle no ticks", bus_idle, 1'b0);
        ticks(4);
        check("R9 idle before threshold", bus_idle, 1'b0);
        ticks(1);
        check("R9 idle at threshold", bus_idle, 1'b1);
        sda_in = 1'b0; #1;
        check("R10 idle drops with sda low", bus_idle, 1'b0);
        ticks(3);
        sda_in = 1'b1;
        ticks(4);
        check("R10 idle count restarted", bus_idle, 1'b0);
        ticks(1);
        check("R10 idle after restarted count", bus_idle, 1'b1);
    endtask

    task automatic t_stall_scl;
        restart(4'd1, 8'd0, 1'b0);
        scl_in = 1'b0; step(2);
        ticks(255);
        check("R2 stall before 256 ticks", stall_flag, 1'b0);
        ticks(1);
        check("R2 stall at 256 ticks", stall_flag, 1'b1);
        scl_in = 1'b1; ticks(10);
        check("R5 stall sticky after release", stall_flag, 1'b1);
        soft_rst = 1'b1; step(1); soft_rst = 1'b0;
        check("R5 soft reset clears stall", stall_flag, 1'b0);
        scl_in = 1'b0; step(2); ticks(256);
        check("R2 stall again after soft reset", stall_flag, 1'b1);
        mon_en = 1'b0; step(1);
        check("R5 disable clears stall", stall_flag, 1'b0);
        mon_en = 1'b1; step(1);
        check("R1 stall zero after re-enable", stall_flag, 1'b0);
    endtask

    task automatic t_stall_limit2;
        restart(4'd2, 8'd0, 1'b0);
        scl_in = 1'b0; step(1);
        ticks(511);
        check("R2 limit 2 before 512", stall_flag, 1'b0);
        ticks(1);
        check("R2 limit 2 at 512", stall_flag, 1'b1);
    endtask

    task automatic t_restart_count;
        restart(4'd1, 8'd0, 1'b0);
        scl_in = 1'b0; step(2);
        ticks(200);
        scl_in = 1'b1; step(1);
        scl_in = 1'b0; step(1);
        ticks(255);
        check("R4 count restarted by edge", stall_flag, 1'b0);
        ticks(1);
        check("R4 stall after restarted count", stall_flag, 1'b1);
    endtask

    task automatic t_select;
        restart(4'd1, 8'd0, 1'b1);
        scl_in = 1'b0; step(2);
        ticks(300);
        check("R3 scl ignored when watching sda", stall_flag, 1'b0);
        sda_in = 1'b0; step(2);
        ticks(255);
        check("R3 sda before 256", stall_flag, 1'b0);
        ticks(1);
        check("R3 sda watched stall", stall_flag, 1'b1);
    endtask

    task automatic t_zero_limit;
        restart(4'd0, 8'd0, 1'b0);
        scl_in = 1'b0; step(2);
        ticks(600);
        check("R6 zero limit never stalls", stall_flag, 1'b0);
    endtask

    task automatic t_tick_gate;
        restart(4'd1, 8'd0, 1'b0);
        scl_in = 1'b0;
        step(2000);
        check("R7 no stall without ticks", stall_flag, 1'b0);
        ticks(255);
        check("R7 stall not early", stall_flag, 1'b0);
        ticks(1);
        check("R7 stall after 256 ticks", stall_flag, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0; tick = 1'b0; mon_en = 1'b0; soft_rst = 1'b0;
        watch_sda = 1'b0; stall_limit = '0; idle_limit = '0;
        scl_in = 1'b1; sda_in = 1'b1;
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_idle_zero();
        t_idle_count();
        t_stall_scl();
        t_stall_limit2();
        t_restart_count();
        t_select();
        t_zero_limit();
        t_tick_gate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule